// File: doc/BRIEF.md
# Byte-to-Serial Configuration Loader

This block accepts bytes written by a microprocessor and emits them as a serial bitstream with a matching serial clock. A write is recognised when a strobe, qualified by all chip-select inputs, ends. The bus inputs are asynchronous to `clk`, so they are synchronised before the edge is detected. A written byte lands in a holding buffer. From there it moves into a parallel-to-serial shift register. Because of this double buffering, the processor can write the next byte while the current one is still shifting out.

The byte write is the stream input. The strobe end acts as "valid" and `rdy_o` acts as "ready". Back-pressure works as follows:
- A writer may only end a strobe while `rdy_o` is high.
- `rdy_o` drops once a byte is taken and rises again when the holding buffer has handed its byte to the shifter.
- A strobe that ends while `rdy_o` is low is dropped, and this is recorded on a sticky overrun flag.
- Data and the last-byte flag must stay stable until `rdy_o` has fallen.

One serial period is two `clk` cycles. The serial clock is low in the first cycle and high in the second, and the data output changes only when the serial clock falls.

Top module: `cfg_byte_serializer`

## Requirements
- R1: After synchronous reset, `rdy_o`=1, `sclk_o`=1, `sdo_o`=1 and `overrun_o`=0.
- R2: A byte is captured only at the end of a strobe during which `wr_i` and every bit of `cs_i` were high. A strobe with any chip select low captures nothing, so `rdy_o` stays high and no serial clock pulse appears.
- R3: `rdy_o` falls at the third `clk` rising edge after the qualified strobe ends.
- R4: When the shifter is idle at capture time, `rdy_o` stays low for exactly 4 `clk` cycles, which is two serial periods.
- R5: When the shifter is still busy at capture time, `rdy_o` rises in the cycle the shifter takes the new byte, and it is never low for more than 18 `clk` cycles. Back-to-back bytes produce serial clock rises exactly 2 cycles apart, with no gap.
- R6: Bits leave LSB first (bit 0 first, bit 7 last), one per serial period. `sdo_o` changes only on a falling `sclk_o` and is sampled on the rising `sclk_o`.
- R7: A byte written with `last_i`=0 sends all 8 bits. A byte written with `last_i`=1 sends only bits 0 to 6. After that, `sclk_o` stays high and `sdo_o` holds bit 6.
- R8: A strobe that ends while `rdy_o` is low is ignored, so its byte is never shifted out. It sets `overrun_o`, which stays set until reset.
- R9: When the shifter has no byte to send, `sclk_o` idles high. After a non-last byte drains, `sdo_o` holds that byte's bit 7.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Serial-domain clock |
| rst | input | 1 | Synchronous reset, active high |
| cs_i | input | NUM_CS | Chip selects, all must be high (asynchronous) |
| wr_i | input | 1 | Write strobe, byte taken when it ends (asynchronous) |
| din_i | input | 8 | Byte from the processor bus |
| last_i | input | 1 | Marks the final byte of the stream |
| rdy_o | output | 1 | High when a new byte may be written |
| sclk_o | output | 1 | Serial clock, idle high |
| sdo_o | output | 1 | Serial data |
| overrun_o | output | 1 | Sticky flag for a write dropped while busy |

## Verification
The bench measures how long `rdy_o` stays low in two situations: a write into an idle shifter, and a write while a byte is still shifting. A design that used one fixed busy time, or that held the buffer until the shifter drained fully, would show the wrong low count or would leave a gap in the serial clock. A scoreboard compares every rising serial clock against the expected LSB-first bit sequence. This exposes reversed bit order, an eighth bit sent for the final byte, a dropped byte that was still shifted out, or a write with a missing chip select that was still accepted. The idle levels of `sclk_o` and `sdo_o` after a final byte and after a normal byte are checked directly, so a design that released the clock or parked the data on the wrong bit fails.

// File: rtl/cfg_ser_pkg.sv
package cfg_ser_pkg;
  localparam int BYTE_W = 8;
  localparam int BIT_IW = $clog2(BYTE_W);

  typedef struct packed {
    logic [BYTE_W-1:0] data;
    logic              last;
  } ser_item_t;
endpackage

// File: rtl/cfg_strobe_sync.sv
module cfg_strobe_sync #(
  parameter int NUM_IN = 4,
  parameter int STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NUM_IN-1:0] raw_i,
  output logic              fall_o
);
  logic [STAGES-1:0] chain [NUM_IN];
  logic [NUM_IN-1:0] synced;
  logic              all_q;

  for (genvar g = 0; g < NUM_IN; g++) begin : g_sync
    always_ff @(posedge clk) begin
      if (rst) chain[g] <= '0;
      else     chain[g] <= {chain[g][STAGES-2:0], raw_i[g]};
    end
    assign synced[g] = chain[g][STAGES-1];
  end

  always_ff @(posedge clk) begin
    if (rst) all_q <= 1'b0;
    else     all_q <= &synced;
  end

  assign fall_o = all_q & ~(&synced);

  // R2
  fall_single_chk: assert property (@(posedge clk) disable iff (rst)
    fall_o |=> !fall_o);
endmodule

// File: rtl/cfg_hold_buf.sv
module cfg_hold_buf
  import cfg_ser_pkg::*;
#(
  parameter int LOAD_WAIT = 4
) (
  input  logic      clk,
  input  logic      rst,
  input  logic      cap_i,
  input  ser_item_t item_i,
  input  logic      shifter_idle_i,
  input  logic      take_i,
  output logic      vld_o,
  output ser_item_t item_o,
  output logic      rdy_o,
  output logic      ovr_o
);
  localparam int CW = $clog2(LOAD_WAIT + 1);
  localparam int BUSY_MAX = 2 * (BYTE_W + 1);

  logic          full_q;
  logic [CW-1:0] wait_q;
  logic          ovr_q;
  ser_item_t     item_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      full_q <= 1'b0;
      wait_q <= '0;
      ovr_q  <= 1'b0;
      item_q <= '0;
    end else begin
      if (take_i) full_q <= 1'b0;
      if (cap_i) begin
        if (!full_q) begin
          full_q <= 1'b1;
          item_q <= item_i;
          wait_q <= shifter_idle_i ? CW'(LOAD_WAIT - 1) : '0;
        end else begin
          ovr_q <= 1'b1;
        end
      end else if (wait_q != '0) begin
        wait_q <= wait_q - 1'b1;
      end
    end
  end

  assign vld_o  = full_q && (wait_q == '0);
  assign item_o = item_q;
  assign rdy_o  = ~full_q;
  assign ovr_o  = ovr_q;

  logic [7:0] busy_len;
  always_ff @(posedge clk) begin
    if (rst || !full_q)      busy_len <= '0;
    else if (busy_len != '1) busy_len <= busy_len + 1'b1;
  end

  // R8
  ovr_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    ovr_q |=> ovr_q);
  // R5
  take_needs_item_chk: assert property (@(posedge clk) disable iff (rst)
    take_i |-> full_q);
  // R5
  busy_bound_chk: assert property (@(posedge clk) disable iff (rst)
    busy_len <= 8'(BUSY_MAX));
endmodule

// File: rtl/cfg_shifter.sv
module cfg_shifter
  import cfg_ser_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      vld_i,
  input  ser_item_t item_i,
  output logic      take_o,
  output logic      idle_o,
  output logic      sclk_o,
  output logic      sdo_o
);
  logic              active_q;
  logic              phase_q;
  logic [BIT_IW-1:0] idx_q;
  logic [BIT_IW-1:0] stop_q;
  logic [BYTE_W-1:0] sreg_q;
  logic              sclk_q;
  logic              sdo_q;
  logic              finish;

  assign finish = active_q && phase_q && (idx_q == stop_q);
  assign take_o = vld_i && (!active_q || finish);
  assign idle_o = ~active_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      active_q <= 1'b0;
      phase_q  <= 1'b0;
      idx_q    <= '0;
      stop_q   <= '0;
      sreg_q   <= '0;
      sclk_q   <= 1'b1;
      sdo_q    <= 1'b1;
    end else begin
      if (active_q) begin
        if (!phase_q) begin
          sclk_q  <= 1'b0;
          sdo_q   <= sreg_q[idx_q];
          phase_q <= 1'b1;
        end else begin
          sclk_q  <= 1'b1;
          phase_q <= 1'b0;
          if (idx_q == stop_q) active_q <= 1'b0;
          else                 idx_q    <= idx_q + 1'b1;
        end
      end
      if (take_o) begin
        sreg_q   <= item_i.data;
        active_q <= 1'b1;
        phase_q  <= 1'b0;
        idx_q    <= '0;
        stop_q   <= item_i.last ? BIT_IW'(BYTE_W - 2) : BIT_IW'(BYTE_W - 1);
      end
    end
  end

  assign sclk_o = sclk_q;
  assign sdo_o  = sdo_q;

  // R9
  idle_clk_high_chk: assert property (@(posedge clk) disable iff (rst)
    !active_q |=> sclk_q);
  // R6
  sdo_on_fall_chk: assert property (@(posedge clk) disable iff (rst)
    !$fell(sclk_q) |-> $stable(sdo_q));
  // R6
  sclk_alternates_chk: assert property (@(posedge clk) disable iff (rst)
    !sclk_q |=> sclk_q);
endmodule

// File: rtl/cfg_byte_serializer.sv
module cfg_byte_serializer
  import cfg_ser_pkg::*;
#(
  parameter int NUM_CS      = 3,
  parameter int SYNC_STAGES = 2,
  parameter int LOAD_WAIT   = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NUM_CS-1:0] cs_i,
  input  logic              wr_i,
  input  logic [BYTE_W-1:0] din_i,
  input  logic              last_i,
  output logic              rdy_o,
  output logic              sclk_o,
  output logic              sdo_o,
  output logic              overrun_o
);
  localparam int NUM_IN = NUM_CS + 1;

  logic      cap;
  logic      vld;
  logic      take;
  logic      idle;
  ser_item_t in_item;
  ser_item_t held;

  assign in_item.data = din_i;
  assign in_item.last = last_i;

  cfg_strobe_sync #(.NUM_IN(NUM_IN), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .raw_i({wr_i, cs_i}), .fall_o(cap)
  );

  cfg_hold_buf #(.LOAD_WAIT(LOAD_WAIT)) u_hold (
    .clk(clk), .rst(rst), .cap_i(cap), .item_i(in_item),
    .shifter_idle_i(idle), .take_i(take), .vld_o(vld), .item_o(held),
    .rdy_o(rdy_o), .ovr_o(overrun_o)
  );

  cfg_shifter u_shift (
    .clk(clk), .rst(rst), .vld_i(vld), .item_i(held), .take_o(take),
    .idle_o(idle), .sclk_o(sclk_o), .sdo_o(sdo_o)
  );

  // R3
  rdy_fall_on_capture_chk: assert property (@(posedge clk) disable iff (rst)
    (cap && rdy_o) |=> !rdy_o);
endmodule

// File: tb/cfg_byte_serializer_test.sv
module cfg_byte_serializer_test;
  localparam int CLK_PERIOD = 10;
  localparam int NCS = 3;

  logic           clk = 1'b0;
  logic           rst = 1'b1;
  logic [NCS-1:0] cs_i = '0;
  logic           wr_i = 1'b0;
  logic [7:0]     din_i = '0;
  logic           last_i = 1'b0;
  logic           rdy_o, sclk_o, sdo_o, overrun_o;

  int checks = 0;
  int failures = 0;
  bit finished = 0;
  bit exp_q[$];
  int cyc = 0;
  int first_rise = -1;
  int last_rise = -1;
  bit prev_sclk = 1'b1;

  always #(CLK_PERIOD/2) clk = ~clk;

  cfg_byte_serializer #(.NUM_CS(NCS)) uut (
    .clk(clk), .rst(rst), .cs_i(cs_i), .wr_i(wr_i), .din_i(din_i),
    .last_i(last_i), .rdy_o(rdy_o), .sclk_o(sclk_o), .sdo_o(sdo_o),
    .overrun_o(overrun_o)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // monitor: pop one expected bit per rising serial clock
  always @(negedge clk) begin
    cyc++;
    if (!rst && sclk_o && !prev_sclk) begin
      if (exp_q.size() == 0) begin
        chk(1'b0, "R2/R8 unexpected serial bit", 1, 0);
      end else begin
        bit e;
        e = exp_q.pop_front();
        chk(sdo_o == e, "R6 serial bit", int'(sdo_o), int'(e));
        if (first_rise < 0) first_rise = cyc;
        last_rise = cyc;
      end
    end
    prev_sclk = sclk_o;
  end

  // driver: push expected bits, then strobe; optionally measure busy length
  task automatic write_byte(input logic [7:0] d, input bit last, input bit expect_ok,
                            input logic [NCS-1:0] cs, input bit wait_rdy,
                            input bit measure, output int low_cnt);
    low_cnt = 0;
    if (wait_rdy) begin
      for (int i = 0; i < 60 && !rdy_o; i++) @(negedge clk);
    end
    if (expect_ok) begin
      for (int b = 0; b < (last ? 7 : 8); b++) exp_q.push_back(d[b]);
    end
    din_i = d; last_i = last; cs_i = cs; wr_i = 1'b1;
    repeat (2) @(negedge clk);
    wr_i = 1'b0;
    if (measure) begin
      for (int i = 0; i < 40; i++) begin
        @(negedge clk);
        if (!rdy_o) low_cnt++;
        else if (low_cnt > 0) break;
      end
    end else begin
      repeat (3) @(negedge clk);
    end
    cs_i = '0;
  endtask

  task automatic drain();
    for (int i = 0; i < 400 && exp_q.size() != 0; i++) @(negedge clk);
    repeat (6) @(negedge clk);
    chk(exp_q.size() == 0, "R6 all expected bits seen", exp_q.size(), 0);
  endtask

  initial begin
    int lc;
    bit clk_ok;
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk(rdy_o == 1'b1, "R1 rdy after reset", rdy_o, 1);
    chk(sclk_o == 1'b1, "R1 sclk after reset", sclk_o, 1);
    chk(sdo_o == 1'b1, "R1 sdo after reset", sdo_o, 1);
    chk(overrun_o == 1'b0, "R1 overrun after reset", overrun_o, 0);

    // R2 missing chip select: no capture
    write_byte(8'h3C, 1'b0, 1'b0, 3'b011, 1'b1, 1'b1, lc);
    chk(lc == 0, "R2 partial select ignored", lc, 0);
    repeat (20) @(negedge clk);
    chk(rdy_o == 1'b1 && sclk_o == 1'b1, "R2 no activity", int'({rdy_o, sclk_o}), 3);

    // R3/R4 idle shifter: busy exactly 4 cycles
    write_byte(8'hA5, 1'b0, 1'b1, 3'b111, 1'b1, 1'b1, lc);
    chk(lc == 4, "R3 R4 busy length idle", lc, 4);
    drain();
    // R9 idle levels after non-last byte: bit7 of A5 = 1
    chk(sclk_o == 1'b1, "R9 sclk idle high", sclk_o, 1);
    chk(sdo_o == 1'b1, "R9 sdo holds bit7", sdo_o, 1);

    // R5 back-to-back stream ending with last byte (R7)
    first_rise = -1;
    write_byte(8'h3C, 1'b0, 1'b1, 3'b111, 1'b1, 1'b0, lc);
    write_byte(8'hC3, 1'b0, 1'b1, 3'b111, 1'b1, 1'b1, lc);
    chk(lc > 4 && lc <= 18, "R5 busy length while shifting", lc, 18);
    write_byte(8'h0F, 1'b0, 1'b1, 3'b111, 1'b1, 1'b0, lc);
    write_byte(8'h96, 1'b1, 1'b1, 3'b111, 1'b1, 1'b0, lc);
    drain();
    chk(last_rise - first_rise == 60, "R5 gap-free stream span", last_rise - first_rise, 60);
    // R7 last byte: clock held high, sdo = bit6 of 0x96 = 0
    clk_ok = 1'b1;
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      if (!sclk_o) clk_ok = 1'b0;
    end
    chk(clk_ok, "R7 sclk held high after last byte", clk_ok, 1);
    chk(sdo_o == 1'b0, "R7 sdo holds bit6", sdo_o, 0);

    // R8 overrun: third write lands while rdy low
    write_byte(8'h5A, 1'b0, 1'b1, 3'b111, 1'b1, 1'b0, lc);
    write_byte(8'h81, 1'b0, 1'b1, 3'b111, 1'b1, 1'b0, lc);
    chk(rdy_o == 1'b0, "R8 rdy low before extra write", rdy_o, 0);
    write_byte(8'hFF, 1'b0, 1'b0, 3'b111, 1'b0, 1'b0, lc);
    chk(overrun_o == 1'b1, "R8 overrun set", overrun_o, 1);
    drain();
    chk(overrun_o == 1'b1, "R8 overrun sticky", overrun_o, 1);
    chk(sdo_o == 1'b1 && sclk_o == 1'b1, "R8 R9 ends on bit7 of 0x81", int'({sdo_o, sclk_o}), 3);

    // R1 reset clears overrun
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(overrun_o == 1'b0, "R1 R8 reset clears overrun", overrun_o, 0);
    chk(rdy_o == 1'b1, "R1 rdy after second reset", rdy_o, 1);

    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      chk(1'b0, "watchdog expired", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule